// File: doc/BRIEF.md
# Processor Status Control Register

This block keeps the status word of a processor core. The low byte holds the control state: two interrupt-disable bits, an instruction-state bit and a five-bit operating-mode field. The top four bits carry condition flags that software may rewrite at any time. The bits between them are reserved and hold their reset value. Software writes arrive with a per-bit write mask and are filtered by the current privilege level. Exception entry comes from the core on a separate path. It loads a new mode and raises the interrupt masks whatever the privilege level. The instruction-state bit has its own dedicated load input, and software can never reach it.

The block decodes the mode field against a sparse set of legal encodings. If an illegal mode is ever loaded, the block enters a locked error state. In that state the interrupt enables are forced off and every update is ignored until reset. The outputs give the whole word, the current mode, the effective interrupt enables, the external state pin, a privilege indication and the error flag.

Top module: `psr_ctrl_reg`

## Requirements
- R1: After a synchronous active-high reset, status_word is 0x000000D3 (Supervisor mode with both interrupt-disable bits set and T=0), lock_err is 0, state_pin is 0 and both enables are 0.
- R2: The low byte is laid out as bit 7 = IRQ disable, bit 6 = FIQ disable, bit 5 = T and bits 4:0 = mode. irq_enable equals the inverse of bit 7 and fiq_enable equals the inverse of bit 6, both forced to 0 while lock_err is set.
- R3: In a privileged mode, a software write (sw_wr_en=1) loads sw_wr_data into bits 7, 6, 4:0 and 31:28 wherever sw_wr_mask is 1, and leaves every bit whose mask bit is 0 unchanged.
- R4: In User mode (mode 10000), a software write changes only the flag bits 31:28. The control byte keeps its value.
- R5: A software write never changes bit 5. T changes only when tstate_wr=1 loads tstate_val, and state_pin always shows bit 5.
- R6: The reserved bits 27:8 keep their value on every software write, whatever the data and mask.
- R7: When exc_en=1, the mode field loads exc_mode, bit 7 is set, bit 6 is set if exc_mask_fiq=1 and otherwise kept, and the flags are kept. This happens regardless of privilege. A software write in the same cycle is discarded.
- R8: The legal mode encodings are 10000, 10001, 10010, 10011, 10111, 11011 and 11111. Loading any other value through either path stores that value and sets lock_err on the same clock edge.
- R9: While lock_err is set, software writes, exception entries and state loads are ignored and lock_err stays set. Only reset clears it.
- R10: privileged is 1 exactly when the stored mode is legal and is not 10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | WORD_W | Software write data |
| sw_wr_mask | input | WORD_W | Per-bit write enable for the software write |
| exc_en | input | 1 | Exception entry strobe from the core |
| exc_mode | input | 5 | Mode loaded on exception entry |
| exc_mask_fiq | input | 1 | Also set the FIQ-disable bit on exception entry |
| tstate_wr | input | 1 | Dedicated state-bit load strobe |
| tstate_val | input | 1 | New value of the state bit |
| status_word | output | WORD_W | Registered status word |
| cur_mode | output | 5 | Current mode field |
| irq_enable | output | 1 | Effective IRQ enable |
| fiq_enable | output | 1 | Effective FIQ enable |
| state_pin | output | 1 | External instruction-state pin |
| privileged | output | 1 | Current mode is legal and not User |
| lock_err | output | 1 | Illegal-mode lock |

## Verification
The bound checker watches several properties on every cycle. It checks that the lock is sticky and freezes the word, that the enables are off while locked and follow the disable bits, and that the state pin moves only on its own strobe. It also checks that a User-mode write leaves the control byte alone, that software writes never move the reserved field, and that exception entry loads the requested mode with IRQ masked. Other behaviour needs the bench's directed scenarios: the exact reset word, the merge of masked data into flags and control bits, and the discarding of a software write that collides with exception entry. A sweep of all 32 mode codes shows which encodings lock the block.

// File: rtl/psr_ctrl_pkg.sv
package psr_ctrl_pkg;
  localparam int CTRL_W = 8;
  localparam int MODE_W = 5;
  localparam int IDIS_BIT = 7;
  localparam int FDIS_BIT = 6;
  localparam int TST_BIT  = 5;

  typedef enum logic [MODE_W-1:0] {
    MD_USR = 5'b10000,
    MD_FIQ = 5'b10001,
    MD_IRQ = 5'b10010,
    MD_SVC = 5'b10011,
    MD_ABT = 5'b10111,
    MD_UND = 5'b11011,
    MD_SYS = 5'b11111
  } mode_e;

  localparam logic [CTRL_W-1:0] CTRL_RESET = {1'b1, 1'b1, 1'b0, MD_SVC};
endpackage

// File: rtl/psr_mode_check.sv
module psr_mode_check
  import psr_ctrl_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output logic              legal
);
  always_comb begin
    unique case (mode)
      MD_USR, MD_FIQ, MD_IRQ, MD_SVC,
      MD_ABT, MD_UND, MD_SYS: legal = 1'b1;
      default:                legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/psr_next_word.sv
module psr_next_word
  import psr_ctrl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int FLAG_W = 4
) (
  input  logic [WORD_W-1:0] cur_word,
  input  logic              priv,
  input  logic              sw_wr_en,
  input  logic [WORD_W-1:0] sw_wr_data,
  input  logic [WORD_W-1:0] sw_wr_mask,
  input  logic              exc_en,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic              exc_mask_fiq,
  input  logic              tstate_wr,
  input  logic              tstate_val,
  output logic [WORD_W-1:0] nxt_word
);
  localparam int FLAG_LO = WORD_W - FLAG_W;

  logic [WORD_W-1:0] allow_mask;
  logic [WORD_W-1:0] eff_mask;
  logic [WORD_W-1:0] sw_word;
  logic [WORD_W-1:0] exc_word;

  // Classify every bit: flags always writable, control bits (except T)
  // only when privileged, T and reserved never.
  for (genvar b = 0; b < WORD_W; b++) begin : g_allow
    if (b >= FLAG_LO) begin : g_flag
      assign allow_mask[b] = 1'b1;
    end else if (b < CTRL_W && b != TST_BIT) begin : g_ctrl
      assign allow_mask[b] = priv;
    end else begin : g_locked
      assign allow_mask[b] = 1'b0;
    end
  end

  assign eff_mask = sw_wr_mask & allow_mask;
  assign sw_word  = (cur_word & ~eff_mask) | (sw_wr_data & eff_mask);

  always_comb begin
    exc_word               = cur_word;
    exc_word[MODE_W-1:0]   = exc_mode;
    exc_word[IDIS_BIT]     = 1'b1;
    exc_word[FDIS_BIT]     = cur_word[FDIS_BIT] | exc_mask_fiq;
  end

  always_comb begin
    if (exc_en)        nxt_word = exc_word;
    else if (sw_wr_en) nxt_word = sw_word;
    else               nxt_word = cur_word;
    if (tstate_wr)     nxt_word[TST_BIT] = tstate_val;
  end
endmodule

// File: rtl/psr_ctrl_reg.sv
module psr_ctrl_reg
  import psr_ctrl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_wr_en,
  input  logic [WORD_W-1:0] sw_wr_data,
  input  logic [WORD_W-1:0] sw_wr_mask,
  input  logic              exc_en,
  input  logic [4:0]        exc_mode,
  input  logic              exc_mask_fiq,
  input  logic              tstate_wr,
  input  logic              tstate_val,
  output logic [WORD_W-1:0] status_word,
  output logic [4:0]        cur_mode,
  output logic              irq_enable,
  output logic              fiq_enable,
  output logic              state_pin,
  output logic              privileged,
  output logic              lock_err
);
  localparam int UPPER_W = WORD_W - CTRL_W;
  localparam logic [WORD_W-1:0] WORD_RESET = {{UPPER_W{1'b0}}, CTRL_RESET};

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] nxt_word;
  logic              lock_q;
  logic              cur_legal;
  logic              nxt_legal;
  logic              priv_now;

  psr_mode_check u_cur_chk (
    .mode  (word_q[MODE_W-1:0]),
    .legal (cur_legal)
  );

  psr_mode_check u_nxt_chk (
    .mode  (nxt_word[MODE_W-1:0]),
    .legal (nxt_legal)
  );

  assign priv_now = cur_legal && (word_q[MODE_W-1:0] != MD_USR);

  psr_next_word #(
    .WORD_W (WORD_W),
    .FLAG_W (FLAG_W)
  ) u_next (
    .cur_word     (word_q),
    .priv         (priv_now),
    .sw_wr_en     (sw_wr_en),
    .sw_wr_data   (sw_wr_data),
    .sw_wr_mask   (sw_wr_mask),
    .exc_en       (exc_en),
    .exc_mode     (exc_mode),
    .exc_mask_fiq (exc_mask_fiq),
    .tstate_wr    (tstate_wr),
    .tstate_val   (tstate_val),
    .nxt_word     (nxt_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= WORD_RESET;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      word_q <= nxt_word;
      if (!nxt_legal) lock_q <= 1'b1;
    end
  end

  // All outputs are functions of flops only.
  assign status_word = word_q;
  assign cur_mode    = word_q[MODE_W-1:0];
  assign irq_enable  = !word_q[IDIS_BIT] && !lock_q;
  assign fiq_enable  = !word_q[FDIS_BIT] && !lock_q;
  assign state_pin   = word_q[TST_BIT];
  assign privileged  = priv_now;
  assign lock_err    = lock_q;
endmodule

// File: rtl/psr_ctrl_chk.sv
module psr_ctrl_chk #(
  parameter int WORD_W = 32,
  parameter int FLAG_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_wr_en,
  input logic              exc_en,
  input logic [4:0]        exc_mode,
  input logic              tstate_wr,
  input logic [WORD_W-1:0] status_word,
  input logic [4:0]        cur_mode,
  input logic              irq_enable,
  input logic              fiq_enable,
  input logic              state_pin,
  input logic              privileged,
  input logic              lock_err
);
  localparam int RSV_HI = WORD_W - FLAG_W - 1;

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    lock_err |=> lock_err);

  assert_lock_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    lock_err |=> $stable(status_word));

  assert_lock_noenable_R2: assert property (@(posedge clk) disable iff (rst)
    lock_err |-> (!irq_enable && !fiq_enable));

  assert_irq_follows_bit_R2: assert property (@(posedge clk) disable iff (rst)
    irq_enable |-> !status_word[7]);

  assert_tstate_dedicated_R5: assert property (@(posedge clk) disable iff (rst)
    !tstate_wr |=> $stable(state_pin));

  assert_user_ctrl_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!privileged && !exc_en && !tstate_wr) |=> $stable(status_word[7:0]));

  assert_reserved_hold_R6: assert property (@(posedge clk) disable iff (rst)
    sw_wr_en |=> $stable(status_word[RSV_HI:8]));

  assert_exc_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (exc_en && !lock_err) |=> (status_word[7] && cur_mode == $past(exc_mode)));
endmodule

bind psr_ctrl_reg psr_ctrl_chk #(.WORD_W(WORD_W), .FLAG_W(FLAG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sw_wr_en    (sw_wr_en),
  .exc_en      (exc_en),
  .exc_mode    (exc_mode),
  .tstate_wr   (tstate_wr),
  .status_word (status_word),
  .cur_mode    (cur_mode),
  .irq_enable  (irq_enable),
  .fiq_enable  (fiq_enable),
  .state_pin   (state_pin),
  .privileged  (privileged),
  .lock_err    (lock_err)
);

// File: tb/sim_psr_ctrl_reg.sv
`timescale 1ns/1ps
module sim_psr_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic [31:0] sw_wr_mask = '0;
  logic        exc_en = 1'b0;
  logic [4:0]  exc_mode = '0;
  logic        exc_mask_fiq = 1'b0;
  logic        tstate_wr = 1'b0;
  logic        tstate_val = 1'b0;
  logic [31:0] status_word;
  logic [4:0]  cur_mode;
  logic        irq_enable, fiq_enable, state_pin, privileged, lock_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  psr_ctrl_reg u0 (
    .clk(clk), .rst(rst), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .sw_wr_mask(sw_wr_mask), .exc_en(exc_en), .exc_mode(exc_mode),
    .exc_mask_fiq(exc_mask_fiq), .tstate_wr(tstate_wr), .tstate_val(tstate_val),
    .status_word(status_word), .cur_mode(cur_mode), .irq_enable(irq_enable),
    .fiq_enable(fiq_enable), .state_pin(state_pin), .privileged(privileged),
    .lock_err(lock_err)
  );

  function automatic bit is_legal(input logic [4:0] m);
    return m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
           m == 5'h17 || m == 5'h1B || m == 5'h1F;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    sw_wr_en = 0; sw_wr_data = '0; sw_wr_mask = '0;
    exc_en = 0; exc_mode = '0; exc_mask_fiq = 0;
    tstate_wr = 0; tstate_val = 0;
  endtask

  // Called at a negedge; inputs are taken at the next posedge, results
  // are observed at the following negedge.
  task automatic apply(input logic we, input logic [31:0] d, input logic [31:0] m,
                       input logic ex, input logic [4:0] em, input logic ef,
                       input logic tw, input logic tv);
    sw_wr_en = we; sw_wr_data = d; sw_wr_mask = m;
    exc_en = ex; exc_mode = em; exc_mask_fiq = ef;
    tstate_wr = tw; tstate_val = tv;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 word", status_word, 32'h0000_00D3);
    check("R1 lock", {31'b0, lock_err}, 0);
    check("R1 enables", {30'b0, irq_enable, fiq_enable}, 0);
    check("R1 state_pin", {31'b0, state_pin}, 0);
    check("R10 priv in Supervisor", {31'b0, privileged}, 1);
  endtask

  task automatic t_priv_write();
    // full mask: reserved and T must not move, I/F/M/flags load
    apply(1, 32'hAFFF_FF3F, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    check("R3 privileged write", status_word, 32'hA000_001F);
    check("R6 reserved kept", {12'b0, status_word[27:8]}, 0);
    check("R5 T not written", {31'b0, state_pin}, 0);
    check("R2 enables open", {30'b0, irq_enable, fiq_enable}, 32'h3);
    apply(1, 32'h0000_0080, 32'h0000_0080, 0, 0, 0, 0, 0);
    check("R3 partial mask", status_word, 32'hA000_009F);
    check("R2 irq masked only", {30'b0, irq_enable, fiq_enable}, 32'h1);
  endtask

  task automatic t_tstate();
    apply(0, 0, 0, 0, 0, 0, 1, 1);
    check("R5 dedicated load", status_word, 32'hA000_00BF);
    check("R5 state_pin", {31'b0, state_pin}, 1);
    apply(1, 32'h0, 32'h0000_0020, 0, 0, 0, 0, 0);
    check("R5 sw cannot clear T", status_word, 32'hA000_00BF);
  endtask

  task automatic t_user();
    apply(1, 32'h0000_0010, 32'h0000_001F, 0, 0, 0, 0, 0);
    check("R3 enter User", status_word, 32'hA000_00B0);
    check("R10 not privileged", {31'b0, privileged}, 0);
    apply(1, 32'h5000_0053, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    check("R4 user write flags only", status_word, 32'h5000_00B0);
  endtask

  task automatic t_exception();
    apply(1, 32'h0, 32'hFFFF_FFFF, 1, 5'h12, 0, 0, 0);
    check("R7 entry wins over sw", status_word, 32'h5000_00B2);
    check("R10 privileged after entry", {31'b0, privileged}, 1);
    apply(0, 0, 0, 1, 5'h11, 1, 0, 0);
    check("R7 entry masks FIQ", status_word, 32'h5000_00F1);
    check("R2 both masked", {30'b0, irq_enable, fiq_enable}, 0);
  endtask

  task automatic t_sweep();
    for (int v = 0; v < 32; v++) begin
      do_reset();
      apply(1, v, 32'h0000_001F, 0, 0, 0, 0, 0);
      check($sformatf("R8 lock for mode %0d", v), {31'b0, lock_err},
            {31'b0, !is_legal(v[4:0])});
      check($sformatf("R8 word for mode %0d", v), status_word, 32'h0000_00C0 | v);
    end
  endtask

  task automatic t_lock();
    do_reset();
    apply(0, 0, 0, 1, 5'h00, 0, 0, 0);
    check("R8 illegal via entry", status_word, 32'h0000_00C0);
    check("R9 lock set", {31'b0, lock_err}, 1);
    check("R10 not privileged locked", {31'b0, privileged}, 0);
    apply(1, 32'h0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    check("R9 sw ignored", status_word, 32'h0000_00C0);
    apply(0, 0, 0, 1, 5'h13, 0, 0, 0);
    check("R9 entry ignored", status_word, 32'h0000_00C0);
    apply(1, 32'h0, 32'h0000_00C0, 0, 0, 0, 1, 1);
    check("R9 T ignored", {31'b0, state_pin}, 0);
    check("R9 enables off", {30'b0, irq_enable, fiq_enable}, 0);
    check("R9 lock held", {31'b0, lock_err}, 1);
    do_reset();
    check("R9 reset clears lock", {31'b0, lock_err}, 0);
    check("R1 word after lock", status_word, 32'h0000_00D3);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    @(negedge clk);
    t_reset();
    t_priv_write();
    t_tstate();
    t_user();
    t_exception();
    t_sweep();
    t_lock();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule